// File: doc/BRIEF.md
# Saturating Multi-Level Set/Reset Register

This block stores one digit of a k-level number system and changes it under three control digits: a raise input, a relative-load input and a lower input. A fourth digit gates all three. The inputs follow a min-style convention. The top level (k-1) means "do nothing", and each step below it adds one unit of drive. The drive of an input is therefore (k-1) minus its level.

The raise input adds its drive to the stored digit. The lower input subtracts its drive. Both stop at the ends of the range and never wrap. The relative-load input replaces the stored digit with its drive, so the digit moves up or down depending on how that value compares with the current one.

The gate digit caps the drive of each input by taking the minimum with it. A gate of 0 freezes the register, and a gate of k-1 passes every input unchanged. A combination is legal only when at most one gated input is active. If two or more are active, the register holds its value and raises a clash flag for that cycle.

Top module: `mvsr_register`

## Requirements
- R1: While the asynchronous reset input is low, the stored digit and the clash flag are both 0.
- R2: When every gated drive is zero, the stored digit keeps its value at the next rising edge and the clash flag is 0.
- R3: The drive of an input is (k-1) minus its level. A level above k-1 counts as k-1, which gives zero drive.
- R4: When only the raise input is active, the next digit is min(digit + drive, k-1).
- R5: When only the lower input is active, the next digit is max(digit - drive, 0).
- R6: When only the relative-load input is active, the next digit equals its gated drive.
- R7: When two or more gated drives are nonzero, the digit holds and the clash flag is 1 after that edge. A legal combination clears the flag at the next edge.
- R8: Each gated drive is min(drive, gate), where a gate above k-1 counts as k-1. A gate of 0 freezes the digit without a clash, and a gate of k-1 passes the full drive.
- R9: The stored digit never exceeds k-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| lvl_up | input | W=$clog2(LEVELS) | Raise control digit |
| lvl_rel | input | W | Relative-load control digit |
| lvl_down | input | W | Lower control digit |
| lvl_gate | input | W | Gate digit, capping every drive |
| state_o | output | W | Stored digit |
| clash_o | output | 1 | Registered flag for an illegal input combination |

## Verification
Two things can compete in the same cycle: an input update and the clash rule. The clash rule suppresses the update, and the gate decides whether a combination counts as a clash at all. The stimulus pairs two active inputs under a full gate, under a zero gate and under a partial gate. Random stimulus keeps each input near neutral most of the time, so legal updates and clashes alternate. A bench model computes the held or updated digit and the flag value after each edge.

// File: rtl/mvsr_pkg.sv
package mvsr_pkg;
  // Index of each control input in the drive vector
  localparam int unsigned IDX_UP   = 0;
  localparam int unsigned IDX_REL  = 1;
  localparam int unsigned IDX_DOWN = 2;
  localparam int unsigned N_CTRL   = 3;
endpackage

// File: rtl/mvsr_rst_sync.sv
module mvsr_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/mvsr_drive.sv
module mvsr_drive #(
  parameter int unsigned LEVELS = 5,
  localparam int unsigned W = $clog2(LEVELS)
) (
  input  logic [W-1:0] level,
  input  logic [W-1:0] gate,
  output logic [W-1:0] drive
);
  localparam logic [W-1:0] MAXV = W'(LEVELS - 1);

  logic [W-1:0] level_c;
  logic [W-1:0] gate_c;
  logic [W-1:0] raw;

  always_comb begin
    level_c = (level > MAXV) ? MAXV : level;
    gate_c  = (gate  > MAXV) ? MAXV : gate;
    raw     = MAXV - level_c;
    drive   = (raw < gate_c) ? raw : gate_c;
  end
endmodule

// File: rtl/mvsr_next.sv
module mvsr_next #(
  parameter int unsigned LEVELS = 5,
  localparam int unsigned W = $clog2(LEVELS)
) (
  input  logic [W-1:0] cur,
  input  logic [W-1:0] up_drv,
  input  logic [W-1:0] rel_drv,
  input  logic [W-1:0] dn_drv,
  output logic [W-1:0] nxt,
  output logic         clash
);
  localparam logic [W:0] MAXW = (W+1)'(LEVELS - 1);

  logic       up_on, rel_on, dn_on;
  logic [W:0] sum;
  logic [W-1:0] up_res, dn_res;

  always_comb begin
    up_on  = (up_drv  != '0);
    rel_on = (rel_drv != '0);
    dn_on  = (dn_drv  != '0);
    clash  = (up_on & rel_on) | (up_on & dn_on) | (rel_on & dn_on);

    sum    = {1'b0, cur} + {1'b0, up_drv};
    up_res = (sum > MAXW) ? MAXW[W-1:0] : sum[W-1:0];
    dn_res = (dn_drv >= cur) ? '0 : (cur - dn_drv);

    nxt = cur;
    if (up_on)       nxt = up_res;
    else if (rel_on) nxt = rel_drv;
    else if (dn_on)  nxt = dn_res;
  end
endmodule

// File: rtl/mvsr_register.sv
module mvsr_register #(
  parameter int unsigned LEVELS = 5,
  localparam int unsigned W = $clog2(LEVELS)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl_up,
  input  logic [W-1:0] lvl_rel,
  input  logic [W-1:0] lvl_down,
  input  logic [W-1:0] lvl_gate,
  output logic [W-1:0] state_o,
  output logic         clash_o
);
  import mvsr_pkg::*;

  localparam logic [W-1:0] MAXV = W'(LEVELS - 1);

  logic         srst_n;
  logic [W-1:0] lvl_vec [N_CTRL];
  logic [W-1:0] drv_vec [N_CTRL];
  logic [W-1:0] state_q, state_d;
  logic         clash_q, clash_d;
  logic         state_en;

  mvsr_rst_sync u_rst (.clk(clk), .arst_n(rst_n), .srst_n(srst_n));

  assign lvl_vec[IDX_UP]   = lvl_up;
  assign lvl_vec[IDX_REL]  = lvl_rel;
  assign lvl_vec[IDX_DOWN] = lvl_down;

  for (genvar g = 0; g < N_CTRL; g++) begin : g_drive
    mvsr_drive #(.LEVELS(LEVELS)) u_drv (
      .level(lvl_vec[g]),
      .gate (lvl_gate),
      .drive(drv_vec[g])
    );
  end

  mvsr_next #(.LEVELS(LEVELS)) u_next (
    .cur    (state_q),
    .up_drv (drv_vec[IDX_UP]),
    .rel_drv(drv_vec[IDX_REL]),
    .dn_drv (drv_vec[IDX_DOWN]),
    .nxt    (state_d),
    .clash  (clash_d)
  );

  // Clock enable: an illegal combination freezes the digit
  assign state_en = !clash_d;

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      state_q <= '0;
      clash_q <= 1'b0;
    end else begin
      if (state_en) state_q <= state_d;
      clash_q <= clash_d;
    end
  end

  assign state_o = state_q;
  assign clash_o = clash_q;

  logic any_drive;
  assign any_drive = (drv_vec[IDX_UP] != '0) || (drv_vec[IDX_REL] != '0) ||
                     (drv_vec[IDX_DOWN] != '0);

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!srst_n)
    !any_drive |=> (state_o == $past(state_o)) && !clash_o);

  p_clash_hold_r7: assert property (@(posedge clk) disable iff (!srst_n)
    clash_d |=> (state_o == $past(state_o)) && clash_o);

  p_gate_lock_r8: assert property (@(posedge clk) disable iff (!srst_n)
    (lvl_gate == '0) |=> (state_o == $past(state_o)) && !clash_o);

  p_raise_monotone_r4: assert property (@(posedge clk) disable iff (!srst_n)
    (drv_vec[IDX_UP] != '0) && !clash_d |=> state_o >= $past(state_o));

  p_lower_monotone_r5: assert property (@(posedge clk) disable iff (!srst_n)
    (drv_vec[IDX_DOWN] != '0) && !clash_d |=> state_o <= $past(state_o));

  p_in_range_r9: assert property (@(posedge clk) disable iff (!srst_n)
    state_o <= MAXV);
endmodule

// File: tb/mvsr_register_test.sv
module mvsr_register_test;
  localparam int unsigned LEVELS = 5;
  localparam int unsigned W = $clog2(LEVELS);
  localparam int MAXI = LEVELS - 1;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [W-1:0] lvl_up, lvl_rel, lvl_down, lvl_gate;
  logic [W-1:0] state_o;
  logic         clash_o;

  int n_cmp = 0;
  int n_bad = 0;
  int exp_state = 0;
  int exp_clash = 0;
  string tag = "R2";
  bit done = 1'b0;

  always #2 clk = ~clk;

  mvsr_register #(.LEVELS(LEVELS)) uut (
    .clk(clk), .rst_n(rst_n),
    .lvl_up(lvl_up), .lvl_rel(lvl_rel), .lvl_down(lvl_down),
    .lvl_gate(lvl_gate), .state_o(state_o), .clash_o(clash_o)
  );

  function automatic int drive_of(int lvl, int gate);
    int l = (lvl > MAXI) ? MAXI : lvl;
    int g = (gate > MAXI) ? MAXI : gate;
    int r = MAXI - l;
    return (r < g) ? r : g;
  endfunction

  task automatic check(string t, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", t, act, exp);
    end
  endtask

  // Check the result of the previous edge, then apply a new combination
  task automatic step(int u, int s, int d, int g, string t);
    int du, ds, dd, cnt;
    @(negedge clk);
    check({tag, " digit"}, int'(state_o), exp_state);
    check({tag, " flag"},  int'(clash_o), exp_clash);
    lvl_up = W'(u); lvl_rel = W'(s); lvl_down = W'(d); lvl_gate = W'(g);
    du = drive_of(u, g); ds = drive_of(s, g); dd = drive_of(d, g);
    cnt = (du != 0) + (ds != 0) + (dd != 0);
    tag = t;
    if (cnt > 1) begin
      exp_clash = 1;
    end else begin
      exp_clash = 0;
      if (du != 0)      exp_state = (exp_state + du > MAXI) ? MAXI : exp_state + du;
      else if (ds != 0) exp_state = ds;
      else if (dd != 0) exp_state = (dd >= exp_state) ? 0 : exp_state - dd;
    end
  endtask

  function automatic int pick_level();
    if ($urandom_range(0, 9) < 6) return $urandom_range(MAXI, (1 << W) - 1);
    return $urandom_range(0, (1 << W) - 1);
  endfunction

  initial begin
    void'($urandom(32'h1f3a));
    rst_n = 1'b0;
    lvl_up = W'(MAXI); lvl_rel = W'(MAXI); lvl_down = W'(MAXI); lvl_gate = W'(MAXI);
    repeat (3) @(negedge clk);
    check("R1 digit in reset", int'(state_o), 0);
    check("R1 flag in reset",  int'(clash_o), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 digit after release", int'(state_o), 0);

    step(MAXI, MAXI, MAXI, MAXI, "R2 idle");
    step(3, MAXI, MAXI, MAXI, "R4 raise by 1");
    step(0, MAXI, MAXI, MAXI, "R4 raise saturates");
    step(1, MAXI, MAXI, MAXI, "R4 raise at top");
    step(MAXI, MAXI, 2, MAXI, "R5 lower by 2");
    step(MAXI, MAXI, 0, MAXI, "R5 lower saturates");
    step(MAXI, MAXI, 3, MAXI, "R5 lower at bottom");
    step(MAXI, 0, MAXI, MAXI, "R6 load full drive");
    step(MAXI, 3, MAXI, MAXI, "R6 load downward");
    step(MAXI, 1, MAXI, MAXI, "R6 load upward");
    step(6, 7, 5, MAXI, "R3 levels above top neutral");
    step(0, MAXI, 0, MAXI, "R7 raise and lower clash");
    step(MAXI, 2, 1, MAXI, "R7 load and lower clash");
    step(MAXI, MAXI, MAXI, MAXI, "R7 flag clears");
    step(0, 0, 0, 0, "R8 gate zero locks all");
    step(MAXI, MAXI, 0, 1, "R8 partial gate caps lower");
    step(MAXI, 0, MAXI, 2, "R8 partial gate caps load");
    step(0, MAXI, MAXI, 7, "R8 gate above top passes");
    step(MAXI, 0, 0, 0, "R8 gate zero hides clash");
    step(2, MAXI, 3, 1, "R7 clash under partial gate");

    for (int i = 0; i < 3000; i++) begin
      int g;
      g = ($urandom_range(0, 9) < 2) ? 0 : pick_level() ^ (($urandom_range(0, 1) != 0) ? 0 : MAXI);
      if (g > (1 << W) - 1) g = MAXI;
      step(pick_level(), pick_level(), pick_level(), g, "R9 random mix");
    end
    step(MAXI, MAXI, MAXI, MAXI, "R2 final idle");
    @(negedge clk);
    check({tag, " digit"}, int'(state_o), exp_state);
    check({tag, " flag"},  int'(clash_o), exp_clash);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule